// File: doc/BRIEF.md
# Condition code restore controller

This block keeps a processor status register next to a software-writable shadow word. The shadow word's condition code field can move in both directions: into the status register, or back from it. Software cannot load the status register straight from a general-purpose value. To put back flags it saved earlier, it writes the shadow word and then issues an arm command. That command copies the upper six shadow bits into the status register.

A phase input `ck1`, sampled by the system clock, controls the feedback. While feedback is armed, each high-to-low transition of `ck1` copies the status condition codes back into the shadow word. One `ck1` period is one step, and each step carries at most one command. A shadow write is protected only for its own step. If the following step is not the arm command, the old status flags overwrite the new shadow flags. A disarm command stops the feedback, so a shadow write made after it survives any number of later steps. The flag field holds C, P, Z and N in bits 15, 14, 13 and 12 of both words. The arm command also loads bits 11 and 10.

Top module: `ccr_ctrl`

## Requirements
- R1: After reset, status and shadow word read zero and feedback is armed.
- R2: A shadow write command loads the full `wdata` word into the shadow word on the next clock edge.
- R3: While armed, each falling `ck1` transition copies status bits 15:12 into shadow bits 15:12. The only exception is the falling transition that ends the step in which the shadow was written.
- R4: While armed, if a shadow write is followed by a step that is not an arm command, that step's falling transition replaces shadow bits 15:12 with the old status flags.
- R5: The arm command loads status bits 15:10 from shadow bits 15:10 and sets feedback armed.
- R6: While armed, an arm command in the step right after a shadow write leaves the written flags in both status bits 15:12 and shadow bits 15:12.
- R7: The disarm command clears the armed state. While disarmed, the shadow word changes only on a shadow write.
- R8: An ALU update command sets status bits 15..12 to `alu_flags` bits 3..0, which hold C, P, Z and N in that order.
- R9: A read command presents the status register on `rd_data` with `rd_vld` high in the following cycle.
- R10: Only the ALU update, the arm command and the arm step's transparent window change the status register. A shadow write never changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ck1 | input | 1 | Clock phase input, high half opens the step |
| wr_sw | input | 1 | Shadow write strobe |
| cc_on | input | 1 | Arm command strobe |
| cc_off | input | 1 | Disarm command strobe |
| alu_upd | input | 1 | ALU flag update strobe |
| rd_stat | input | 1 | Status read strobe |
| wdata | input | 16 | Data for a shadow write |
| alu_flags | input | 4 | New flags {C,P,Z,N} |
| status_o | output | 16 | Status register |
| sw_o | output | 16 | Shadow word |
| rd_data | output | 16 | Status captured by a read |
| rd_vld | output | 1 | Read data valid |

## Verification
The assertions assume that at most one command strobe is high in any cycle. They also assume commands arrive only while `ck1` is high, so that no command coincides with a falling transition. The bench holds each `ck1` half for four clock cycles and raises a single strobe in the second high cycle. Its random steps therefore keep to these rules, while the order of commands and the data values vary freely.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int unsigned CCR_DW     = 16;
  localparam int unsigned CCR_FLAG_W = 4;
  localparam int unsigned CCR_LOAD_W = 6;
endpackage

// File: rtl/ccr_phase.sv
module ccr_phase (
  input  logic clk,
  input  logic rst,
  input  logic ck1,
  output logic ck1_high,
  output logic ck1_fall
);
  logic ck1_q;

  always_ff @(posedge clk) begin
    if (rst) ck1_q <= 1'b0;
    else     ck1_q <= ck1;
  end

  assign ck1_high = ck1;
  assign ck1_fall = ck1_q & ~ck1;

  // R3: a falling transition lasts a single cycle
  a_r3_fall_single: assert property (@(posedge clk) disable iff (rst)
    ck1_fall |=> !ck1_fall);
endmodule

// File: rtl/ccr_track.sv
module ccr_track (
  input  logic clk,
  input  logic rst,
  input  logic wr_sw,
  input  logic cc_on,
  input  logic cc_off,
  input  logic ck1_fall,
  output logic fb_en,
  output logic ccon_step,
  output logic wr_step
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fb_en     <= 1'b1;
      ccon_step <= 1'b0;
      wr_step   <= 1'b0;
    end else begin
      if (cc_on)       fb_en <= 1'b1;
      else if (cc_off) fb_en <= 1'b0;
      if (cc_on)         ccon_step <= 1'b1;
      else if (ck1_fall) ccon_step <= 1'b0;
      if (wr_sw)         wr_step <= 1'b1;
      else if (ck1_fall) wr_step <= 1'b0;
    end
  end

  a_r5_arm: assert property (@(posedge clk) disable iff (rst)
    cc_on |=> fb_en);
  a_r7_disarm: assert property (@(posedge clk) disable iff (rst)
    (cc_off && !cc_on) |=> !fb_en);
  a_r2_single_cmd: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_sw, cc_on, cc_off}));
endmodule

// File: rtl/ccr_regs.sv
module ccr_regs #(
  parameter int unsigned DW     = ccr_pkg::CCR_DW,
  parameter int unsigned FLAG_W = ccr_pkg::CCR_FLAG_W,
  parameter int unsigned LOAD_W = ccr_pkg::CCR_LOAD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_sw,
  input  logic              cc_on,
  input  logic              alu_upd,
  input  logic              rd_stat,
  input  logic [DW-1:0]     wdata,
  input  logic [FLAG_W-1:0] alu_flags,
  input  logic              fb_en,
  input  logic              ccon_step,
  input  logic              wr_step,
  input  logic              ck1_high,
  input  logic              ck1_fall,
  output logic [DW-1:0]     status,
  output logic [DW-1:0]     sw,
  output logic [DW-1:0]     rd_data,
  output logic              rd_vld
);
  localparam int unsigned FLAG_LO = DW - FLAG_W;
  localparam int unsigned LOAD_LO = DW - LOAD_W;

  logic          xpar;
  logic          fb_fire;
  logic [DW-1:0] st_d;
  logic [DW-1:0] sw_d;

  assign xpar    = fb_en & ccon_step & ck1_high;
  assign fb_fire = fb_en & ck1_fall & ~wr_step;

  always_comb begin
    st_d = status;
    if (cc_on)        st_d[DW-1:LOAD_LO] = sw[DW-1:LOAD_LO];
    else if (xpar)    st_d[DW-1:FLAG_LO] = sw[DW-1:FLAG_LO];
    else if (alu_upd) st_d[DW-1:FLAG_LO] = alu_flags;
  end

  always_comb begin
    sw_d = sw;
    if (wr_sw)        sw_d = wdata;
    else if (fb_fire) sw_d[DW-1:FLAG_LO] = status[DW-1:FLAG_LO];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status  <= '0;
      sw      <= '0;
      rd_data <= '0;
      rd_vld  <= 1'b0;
    end else begin
      status <= st_d;
      sw     <= sw_d;
      rd_vld <= rd_stat;
      if (rd_stat) rd_data <= status;
    end
  end

  a_r10_status_hold: assert property (@(posedge clk) disable iff (rst)
    (!cc_on && !alu_upd && !xpar) |=> $stable(status));
  a_r5_load: assert property (@(posedge clk) disable iff (rst)
    cc_on |=> status[DW-1:LOAD_LO] == $past(sw[DW-1:LOAD_LO]));
  a_r3_feedback: assert property (@(posedge clk) disable iff (rst)
    (ck1_fall && fb_en && !wr_step && !wr_sw) |=>
      sw[DW-1:FLAG_LO] == $past(status[DW-1:FLAG_LO]));
  a_r7_sw_hold: assert property (@(posedge clk) disable iff (rst)
    (!fb_en && !wr_sw) |=> $stable(sw));
  a_r2_write: assert property (@(posedge clk) disable iff (rst)
    wr_sw |=> sw == $past(wdata));
  a_r9_read: assert property (@(posedge clk) disable iff (rst)
    rd_stat |=> (rd_vld && rd_data == $past(status)));
endmodule

// File: rtl/ccr_ctrl.sv
module ccr_ctrl #(
  parameter int unsigned DW     = ccr_pkg::CCR_DW,
  parameter int unsigned FLAG_W = ccr_pkg::CCR_FLAG_W,
  parameter int unsigned LOAD_W = ccr_pkg::CCR_LOAD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ck1,
  input  logic              wr_sw,
  input  logic              cc_on,
  input  logic              cc_off,
  input  logic              alu_upd,
  input  logic              rd_stat,
  input  logic [DW-1:0]     wdata,
  input  logic [FLAG_W-1:0] alu_flags,
  output logic [DW-1:0]     status_o,
  output logic [DW-1:0]     sw_o,
  output logic [DW-1:0]     rd_data,
  output logic              rd_vld
);
  logic ck1_high, ck1_fall;
  logic fb_en, ccon_step, wr_step;

  ccr_phase u_phase (
    .clk      (clk),
    .rst      (rst),
    .ck1      (ck1),
    .ck1_high (ck1_high),
    .ck1_fall (ck1_fall)
  );

  ccr_track u_track (
    .clk       (clk),
    .rst       (rst),
    .wr_sw     (wr_sw),
    .cc_on     (cc_on),
    .cc_off    (cc_off),
    .ck1_fall  (ck1_fall),
    .fb_en     (fb_en),
    .ccon_step (ccon_step),
    .wr_step   (wr_step)
  );

  ccr_regs #(.DW(DW), .FLAG_W(FLAG_W), .LOAD_W(LOAD_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_sw     (wr_sw),
    .cc_on     (cc_on),
    .alu_upd   (alu_upd),
    .rd_stat   (rd_stat),
    .wdata     (wdata),
    .alu_flags (alu_flags),
    .fb_en     (fb_en),
    .ccon_step (ccon_step),
    .wr_step   (wr_step),
    .ck1_high  (ck1_high),
    .ck1_fall  (ck1_fall),
    .status    (status_o),
    .sw        (sw_o),
    .rd_data   (rd_data),
    .rd_vld    (rd_vld)
  );

  a_r1_alu_cmd_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_sw, cc_on, cc_off, alu_upd, rd_stat}));
endmodule

// File: tb/ccr_ctrl_tb_top.sv
module ccr_ctrl_tb_top;
  localparam int C_NONE = 0, C_WR = 1, C_ON = 2, C_OFF = 3, C_ALU = 4, C_RD = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ck1 = 1'b0;
  logic        wr_sw = 1'b0, cc_on = 1'b0, cc_off = 1'b0, alu_upd = 1'b0, rd_stat = 1'b0;
  logic [15:0] wdata = '0;
  logic [3:0]  alu_flags = '0;
  logic [15:0] status_o, sw_o, rd_data;
  logic        rd_vld;

  int total = 0;
  int bad   = 0;
  logic [15:0] m_st, m_sw;
  logic        m_en;

  always #2 clk = ~clk;

  ccr_ctrl dut_i (
    .clk(clk), .rst(rst), .ck1(ck1), .wr_sw(wr_sw), .cc_on(cc_on),
    .cc_off(cc_off), .alu_upd(alu_upd), .rd_stat(rd_stat), .wdata(wdata),
    .alu_flags(alu_flags), .status_o(status_o), .sw_o(sw_o),
    .rd_data(rd_data), .rd_vld(rd_vld)
  );

  function automatic logic [15:0] exp_status(input int c, input logic [15:0] st,
                                             input logic [15:0] sw, input logic [3:0] f);
    logic [15:0] r = st;
    if (c == C_ON)  r[15:10] = sw[15:10];
    if (c == C_ALU) r[15:12] = f;
    return r;
  endfunction

  function automatic logic [15:0] exp_sw(input int c, input logic [15:0] st_new,
                                         input logic [15:0] sw, input logic en,
                                         input logic [15:0] d);
    logic [15:0] r = sw;
    if (c == C_WR) r = d;
    else if (en) r[15:12] = st_new[15:12];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int c, input logic [15:0] d, input logic [3:0] f, input string tag);
    logic [15:0] nst;
    @(negedge clk) ck1 = 1'b1;
    @(negedge clk);
    wdata = d; alu_flags = f;
    wr_sw = (c == C_WR); cc_on = (c == C_ON); cc_off = (c == C_OFF);
    alu_upd = (c == C_ALU); rd_stat = (c == C_RD);
    @(negedge clk);
    {wr_sw, cc_on, cc_off, alu_upd, rd_stat} = '0;
    if (c == C_RD) begin
      chk({"R9 rd_vld ", tag}, {15'd0, rd_vld}, 16'd1);
      chk({"R9 rd_data ", tag}, rd_data, m_st);
    end
    nst = exp_status(c, m_st, m_sw, f);
    if (c == C_ON) m_en = 1'b1;
    if (c == C_OFF) m_en = 1'b0;
    m_sw = exp_sw(c, nst, m_sw, m_en, d);
    m_st = nst;
    @(negedge clk);
    @(negedge clk) ck1 = 1'b0;
    repeat (3) @(negedge clk);
    chk({"status ", tag}, status_o, m_st);
    chk({"sw ", tag}, sw_o, m_sw);
  endtask

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd1234);
    m_st = '0; m_sw = '0; m_en = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset status", status_o, 16'h0000);
    chk("R1 reset sw", sw_o, 16'h0000);
    // R1 armed after reset, R8 ALU update, R3 feedback copies flags
    step(C_ALU, 16'h0, 4'b1010, "R1 R8 R3 alu after reset");
    chk("R3 sw flags follow", {12'd0, sw_o[15:12]}, 16'h000A);
    // R2 full write, R10 status untouched
    step(C_WR, 16'h5C3F, 4'h0, "R2 R10 write");
    // R4 clobber on next non-arm step
    step(C_NONE, 16'h0, 4'h0, "R4 clobber");
    chk("R4 sw flags", {12'd0, sw_o[15:12]}, 16'h000A);
    // R6 write then arm: flags survive; R5 load of 15:10
    step(C_WR, 16'h9400, 4'h0, "R6 write");
    step(C_ON, 16'h0, 4'h0, "R5 R6 arm");
    chk("R6 status flags", {10'd0, status_o[15:10]}, 16'h0025);
    // R7 disarm preserves shadow across steps
    step(C_OFF, 16'h0, 4'h0, "R7 off");
    step(C_WR, 16'h6C00, 4'h0, "R7 write");
    step(C_ALU, 16'h0, 4'hF, "R7 alu");
    step(C_NONE, 16'h0, 4'h0, "R7 idle");
    chk("R7 sw kept", sw_o, 16'h6C00);
    step(C_ON, 16'h0, 4'h0, "R5 rearm");
    chk("R5 status load", {10'd0, status_o[15:10]}, 16'h001B);
    step(C_RD, 16'h0, 4'h0, "R9 read");
    for (int i = 0; i < 400; i++) begin
      int c;
      c = int'($urandom % 6);
      step(c, 16'($urandom), 4'($urandom), "random");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule